// File: doc/BRIEF.md
# Shared Queue-Status Flag Bus Ownership Controller

Several queue devices in a bank can share one 4-bit status bus, one bit for each queue. This controller sits in each device and decides, cycle by cycle, whether that device drives the bus. When it drives, it places the status of its four queues on the bus. When it does not, it releases the bus. Tri-state is modelled by an output-enable, and the bus data is forced to zero while released.

Ownership works in one of two ways, chosen by straps that are captured while reset is held low.

- **Addressed operation.** An external agent picks the owner by putting a device ID on the upper address bits and raising a strobe.
- **Ring operation.** The devices are wired in a loop, with each token output feeding the next device's token input. The device strapped as master starts the circulation and marks each lap with a one-cycle sync pulse.

A third strap chooses which status the bus carries: packet-ready or almost-level.

Top module: `qflag_bus_ctrl`

## Requirements
- R1: While rst_ni is low, and afterwards until the device first gains ownership, bus_oe_o, token_o and sync_o are low and bus_o is all zeros.
- R2: In addressed mode (flag_mode_i low during reset), a rising edge that sees strobe_i high, qsel_i low and addr_i[4:2] equal to dev_id_i makes bus_oe_o high starting in the next cycle. addr_i[1:0] has no effect on this match.
- R3: In addressed mode the owner may change on consecutive edges. An edge with strobe_i low leaves ownership unchanged.
- R4: In addressed mode an edge with strobe_i and qsel_i both high is ignored, and ownership stays as it was.
- R5: In addressed mode no device drives the bus after reset until it is selected. An accepted strobe carrying a different ID drops bus_oe_o in the next cycle.
- R6: In ring mode (flag_mode_i high during reset), the master device (master_i high during reset) owns the bus in the cycle after the first rising edge following reset release.
- R7: In ring mode token_o is high exactly in the cycles when the device owns the bus. A device that sees token_i high at an edge owns the bus in the next cycle. In a closed ring exactly one device owns the bus in every cycle, and ownership passes in ring order.
- R8: sync_o is high only on the master device, and only in cycles when it owns the ring. For a ring of N devices it recurs every N cycles. sync_o and token_o stay low in addressed mode.
- R9: While owning, bus_o[k] carries the status of queue k+1 (k = 0..3). While not owning, bus_oe_o is low and bus_o is zero.
- R10: If pkt_mode_i was high during reset, the bus carries ready_i. If it was low, the bus carries almost_i. The timing is the same in both cases.
- R11: Changes on flag_mode_i, master_i and pkt_mode_i after reset release have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; straps are captured on clock edges while it is low |
| flag_mode_i | input | 1 | Ownership strap: 0 addressed, 1 ring |
| master_i | input | 1 | Master strap for ring operation |
| pkt_mode_i | input | 1 | Status strap: 1 packet-ready, 0 almost-level |
| dev_id_i | input | 3 | This device's ID |
| addr_i | input | 5 | Address bus; bits 4:2 carry the ID being selected |
| strobe_i | input | 1 | Bus-selection strobe |
| qsel_i | input | 1 | Queue-selection request; blocks the strobe in the same cycle |
| token_i | input | 1 | Token from the previous device in the ring |
| almost_i | input | 4 | Almost-level status per queue |
| ready_i | input | 4 | Packet-ready status per queue |
| bus_o | output | 4 | Status bus data (zero while released) |
| bus_oe_o | output | 1 | Bus output-enable (ownership) |
| token_o | output | 1 | Token to the next device; high while owning in ring mode |
| sync_o | output | 1 | Lap marker from the master in ring mode |

## Verification
The assertions assume the straps are stable for at least one clock edge while rst_ni is low. In ring mode they also assume token_i comes from a closed ring holding exactly one master. The stimulus satisfies both conditions:
- Every reset is held for several clocks with the straps already set.
- Four instances are wired in a loop, and only ID 0 is strapped as master.
- Strobes, address bits and strap toggles are applied freely after reset, including in ring mode, where they must not disturb the rotation.

// File: rtl/qflag_pkg.sv
package qflag_pkg;
  typedef enum logic {
    FM_DIRECT = 1'b0,
    FM_POLLED = 1'b1
  } fmode_e;
endpackage

// File: rtl/qflag_straps.sv
module qflag_straps
  import qflag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   flag_mode_i,
  input  logic   master_i,
  input  logic   pkt_mode_i,
  output fmode_e mode_o,
  output logic   master_o,
  output logic   pkt_o
);
  // captured only while reset is held; frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_o   <= fmode_e'(flag_mode_i);
      master_o <= master_i;
      pkt_o    <= pkt_mode_i;
    end
  end
endmodule

// File: rtl/qflag_owner.sv
module qflag_owner
  import qflag_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  fmode_e          mode_i,
  input  logic            master_i,
  input  logic [ID_W-1:0] dev_id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic            strobe_i,
  input  logic            qsel_i,
  input  logic            token_i,
  output logic            own_o
);
  localparam int ID_LSB = ADDR_W - ID_W;

  logic first_q;
  logic sel_ok;
  logic id_hit;

  assign sel_ok = strobe_i & ~qsel_i;  // queue select wins the cycle
  assign id_hit = (addr_i[ADDR_W-1:ID_LSB] == dev_id_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_o   <= 1'b0;
      first_q <= 1'b1;
    end else begin
      first_q <= 1'b0;
      if (mode_i == FM_POLLED) begin
        own_o <= first_q ? master_i : token_i;
      end else if (sel_ok) begin
        own_o <= id_hit;
      end
    end
  end

  AST_DIR_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FM_DIRECT && strobe_i && !qsel_i && id_hit) |=> own_o);  // R2
  AST_DIR_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FM_DIRECT && !strobe_i) |=> $stable(own_o));  // R3
  AST_DIR_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FM_DIRECT && strobe_i && qsel_i) |=> $stable(own_o));  // R4
  AST_DIR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FM_DIRECT && strobe_i && !qsel_i && !id_hit) |=> !own_o);  // R5
  AST_RING_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FM_POLLED && !first_q && token_i) |=> own_o);  // R7
  AST_RING_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FM_POLLED && first_q && master_i) |=> own_o);  // R6
endmodule

// File: rtl/qflag_drive.sv
module qflag_drive
  import qflag_pkg::*;
#(
  parameter int NQ = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fmode_e        mode_i,
  input  logic          master_i,
  input  logic          pkt_i,
  input  logic          own_i,
  input  logic [NQ-1:0] almost_i,
  input  logic [NQ-1:0] ready_i,
  output logic [NQ-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          token_o,
  output logic          sync_o
);
  logic [NQ-1:0] stat;
  logic          polled;

  assign polled = (mode_i == FM_POLLED);

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign stat[q]  = pkt_i ? ready_i[q] : almost_i[q];
    assign bus_o[q] = own_i & stat[q];
  end

  assign bus_oe_o = own_i;
  assign token_o  = polled & own_i;
  assign sync_o   = polled & master_i & own_i;

  AST_SYNC_ONLY_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (token_o && bus_oe_o));  // R8
  AST_TOKEN_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |-> bus_oe_o);  // R7
endmodule

// File: rtl/qflag_bus_ctrl.sv
module qflag_bus_ctrl
  import qflag_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int ID_W   = 3,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_mode_i,
  input  logic              master_i,
  input  logic              pkt_mode_i,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_i,
  input  logic              qsel_i,
  input  logic              token_i,
  input  logic [NQ-1:0]     almost_i,
  input  logic [NQ-1:0]     ready_i,
  output logic [NQ-1:0]     bus_o,
  output logic              bus_oe_o,
  output logic              token_o,
  output logic              sync_o
);
  fmode_e mode;
  logic   master;
  logic   pkt;
  logic   own;

  qflag_straps u_straps (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flag_mode_i (flag_mode_i),
    .master_i    (master_i),
    .pkt_mode_i  (pkt_mode_i),
    .mode_o      (mode),
    .master_o    (master),
    .pkt_o       (pkt)
  );

  qflag_owner #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_owner (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .master_i (master),
    .dev_id_i (dev_id_i),
    .addr_i   (addr_i),
    .strobe_i (strobe_i),
    .qsel_i   (qsel_i),
    .token_i  (token_i),
    .own_o    (own)
  );

  qflag_drive #(.NQ(NQ)) u_drive (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .master_i (master),
    .pkt_i    (pkt),
    .own_i    (own),
    .almost_i (almost_i),
    .ready_i  (ready_i),
    .bus_o    (bus_o),
    .bus_oe_o (bus_oe_o),
    .token_o  (token_o),
    .sync_o   (sync_o)
  );

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> (bus_o == '0));  // R9
  AST_DIRECT_NO_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == FM_DIRECT) |-> (!token_o && !sync_o));  // R8
endmodule

// File: tb/qflag_bus_ctrl_test.sv
`timescale 1ns/1ps
module qflag_bus_ctrl_test;
  localparam int NDEV = 4;
  localparam int NQ   = 4;

  typedef struct {
    logic [NDEV-1:0]         oe;
    logic [NDEV-1:0]         tok;
    logic [NDEV-1:0]         syn;
    logic [NDEV-1:0][NQ-1:0] bus;
    logic                    ring;
    string                   tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flag_mode = 1'b0, pkt_mode = 1'b0;
  logic [4:0] addr = '0;
  logic strobe = 1'b0, qsel = 1'b0;
  logic [NQ-1:0] alm [NDEV];
  logic [NQ-1:0] rdy [NDEV];
  logic [NQ-1:0] bus [NDEV];
  logic [NDEV-1:0] oe, tok, syn;

  int checks = 0, fails = 0, cyc = 0, last_sync = -1;
  bit done = 1'b0;
  exp_t sb[$];

  // model state
  logic ring_m, pkt_m, first_m;
  logic [NDEV-1:0] own_m;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    qflag_bus_ctrl uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .flag_mode_i (flag_mode),
      .master_i    (i == 0),
      .pkt_mode_i  (pkt_mode),
      .dev_id_i    (3'(i)),
      .addr_i      (addr),
      .strobe_i    (strobe),
      .qsel_i      (qsel),
      .token_i     (tok[(i + NDEV - 1) % NDEV]),
      .almost_i    (alm[i]),
      .ready_i     (rdy[i]),
      .bus_o       (bus[i]),
      .bus_oe_o    (oe[i]),
      .token_o     (tok[i]),
      .sync_o      (syn[i])
    );
  end

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic do_reset(input logic ring, input logic pkt);
    @(negedge clk);
    rst_n = 1'b0; flag_mode = ring; pkt_mode = pkt;
    strobe = 1'b0; qsel = 1'b0;
    repeat (3) @(negedge clk);
    chk(oe == '0 && tok == '0 && syn == '0, "R1",
        $sformatf("in reset oe=%b tok=%b syn=%b exp 0", oe, tok, syn));
    ring_m = ring; pkt_m = pkt; first_m = 1'b1; own_m = '0;
    last_sync = -1;
    rst_n = 1'b1;
  endtask

  // drive one cycle at a negedge, push the expected state after the next edge
  task automatic step(input logic s, input logic q, input logic [4:0] a,
                      input logic strap_noise, input string tag);
    exp_t e;
    strobe = s; qsel = q; addr = a;
    if (strap_noise) begin flag_mode = ~flag_mode; pkt_mode = ~pkt_mode; end
    for (int i = 0; i < NDEV; i++) begin
      alm[i] = 4'(cyc * 3 + i * 5);
      rdy[i] = ~alm[i] ^ 4'(i + 6);
    end
    if (ring_m) begin
      own_m = first_m ? 4'b0001 : {own_m[NDEV-2:0], own_m[NDEV-1]};
    end else if (s && !q) begin
      own_m = (a[4:2] < NDEV) ? (NDEV'(1) << a[4:2]) : '0;
    end
    first_m = 1'b0;
    e.oe = own_m;
    e.tok = ring_m ? own_m : '0;
    e.syn = (ring_m && own_m[0]) ? 4'b0001 : '0;
    for (int i = 0; i < NDEV; i++)
      e.bus[i] = own_m[i] ? (pkt_m ? rdy[i] : alm[i]) : '0;
    e.ring = ring_m;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (sb.size() > 0) begin
        exp_t e;
        logic [NDEV-1:0][NQ-1:0] got;
        e = sb.pop_front();
        for (int i = 0; i < NDEV; i++) got[i] = bus[i];
        chk(oe == e.oe && tok == e.tok && syn == e.syn, e.tag,
            $sformatf("oe=%b tok=%b syn=%b exp oe=%b tok=%b syn=%b",
                      oe, tok, syn, e.oe, e.tok, e.syn));
        chk(got == e.bus, {e.tag, " R9 R10"},
            $sformatf("bus=%h exp %h", got, e.bus));
        if (e.ring) begin
          chk($countones(oe) == 1, "R7",
              $sformatf("owners=%0d exp 1", $countones(oe)));
          if (syn[0]) begin
            if (last_sync >= 0)
              chk(cyc - last_sync == NDEV, "R8",
                  $sformatf("sync gap=%0d exp %0d", cyc - last_sync, NDEV));
            last_sync = cyc;
          end
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < NDEV; i++) begin alm[i] = '0; rdy[i] = '0; end
    // ring mode, packet-ready status
    do_reset(1'b1, 1'b1);
    step(1'b1, 1'b0, 5'b01000, 1'b0, "R6");
    for (int k = 0; k < 13; k++)
      step(k[0], k[1], 5'(k * 7), k == 4, "R7 R11");
    // addressed mode, almost-level status
    do_reset(1'b0, 1'b0);
    step(1'b0, 1'b0, 5'b01000, 1'b0, "R5");
    step(1'b0, 1'b1, 5'b00000, 1'b0, "R5");
    step(1'b1, 1'b0, {3'd2, 2'b11}, 1'b0, "R2");
    step(1'b0, 1'b0, {3'd0, 2'b00}, 1'b0, "R3");
    step(1'b1, 1'b0, {3'd1, 2'b00}, 1'b0, "R3");
    step(1'b1, 1'b0, {3'd3, 2'b01}, 1'b1, "R3 R11");
    step(1'b1, 1'b1, {3'd0, 2'b00}, 1'b0, "R4");
    step(1'b0, 1'b1, {3'd1, 2'b10}, 1'b0, "R4");
    step(1'b1, 1'b0, {3'd6, 2'b00}, 1'b0, "R5");
    step(1'b0, 1'b0, {3'd0, 2'b00}, 1'b0, "R5");
    step(1'b1, 1'b0, {3'd0, 2'b10}, 1'b1, "R2 R11");
    step(1'b0, 1'b0, {3'd2, 2'b00}, 1'b0, "R3");
    step(1'b1, 1'b0, {3'd0, 2'b01}, 1'b0, "R2");
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    wait (done || cyc > 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule